// File: doc/BRIEF.md
# Multilane Serial ADC Frame Deserializer

This block turns the serial output of an eight-channel converter back into parallel samples. Each channel drives its own one-bit data lane. All lanes share one bit clock and one frame clock. The bit clock is double data rate, so one bit arrives on every transition of it. The frame clock rises at the first bit of each word. The block runs on a single fast system clock. It samples the bit clock, the frame clock and the lanes through one matched synchronizer chain, and it takes one bit on each detected bit-clock transition.

For every complete frame, the block presents all eight lane words together on one flat output bus and raises a one-cycle valid strobe. Three configuration inputs are read at each frame start. They select a 12-bit or 10-bit word, the order in which bits arrive (MSB or LSB first), and whether the result stays offset binary or is converted to two's complement. A sticky flag reports a frame-clock rise seen anywhere other than a word boundary. Each sample is the converter's input from eight sample-clock cycles earlier. Downstream logic must account for that fixed latency, because this block does not tag it.

Top module: `adc_frame_deser`

## Requirements
- R1: Each frame rebuilds one word per lane. Lane l appears at `samp_o[12*l+11:12*l]`. All lanes update in the same cycle, and `samp_valid_o` is high for exactly that one cycle, the cycle after the frame's last bit is taken.
- R2: With `cfg_short_i`=0 a frame holds 12 bits per lane, and the output is the 12-bit word.
- R3: With `cfg_short_i`=1 a frame holds 10 bits per lane. The word is placed in bits [11:2] of its lane field, and bits [1:0] are zero.
- R4: With `cfg_lsb_first_i`=0 the first bit of a frame is the word's most significant bit. With `cfg_lsb_first_i`=1 the first bit is its least significant bit.
- R5: A bit is taken on every transition of `bclk_i`, rising and falling alike. A 12-bit frame therefore spans six bit-clock periods.
- R6: A bit at which `fclk_i` is 1 and at the previous taken bit was 0 is bit 0 of a word. Until the first such rise after reset, bits are ignored and no valid strobe appears. That first rise does not set `align_lost_o`.
- R7: With `cfg_twos_i`=1, bit 11 of each output lane field is inverted, in both word lengths. With `cfg_twos_i`=0 the offset-binary word is passed unchanged.
- R8: A frame-clock rise at any bit position other than 0 sets `align_lost_o`. The flag stays at 1 until reset. The unfinished word is dropped, and counting restarts with that bit as bit 0.
- R9: The configuration inputs are captured at each frame's first bit. A change in the middle of a frame affects only the next frame.
- R10: During and right after reset, `samp_o` is 0, `samp_valid_o` is 0 and `align_lost_o` is 0.
- R11: `samp_o` keeps its value in every cycle where `samp_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Shared double-data-rate bit clock |
| fclk_i | input | 1 | Frame clock; its rise marks bit 0 of a word |
| lane_i | input | 8 | One serial data bit per lane |
| cfg_short_i | input | 1 | 1 selects 10-bit words, 0 selects 12-bit words |
| cfg_lsb_first_i | input | 1 | 1 selects least-significant-bit-first order |
| cfg_twos_i | input | 1 | 1 selects two's-complement output |
| samp_o | output | 96 | Eight 12-bit lane words, lane 0 in the low bits |
| samp_valid_o | output | 1 | One-cycle strobe when all lane words update |
| align_lost_o | output | 1 | Sticky flag for a misplaced frame-clock rise |

## Verification
The assertions check four things on every cycle: the valid strobe lasts one cycle and follows the word-complete decision, the output holds between strobes, the alignment flag never clears once set, and the two pad bits are zero for every 10-bit word. Whether the lane bits land in the right order and polarity can only be shown by the bench, which compares each lane word against a value it computes arithmetically. The same holds for configuration being captured only at frame starts, for bits before the first lock being discarded, and for a truncated frame being dropped and followed by a correct one. These are exercised by sweeping every combination of word length, bit order and coding over several data patterns.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;

  // Per-frame configuration, captured at bit 0 of a word.
  typedef struct packed {
    logic short_w;    // 10-bit word when set
    logic lsb_first;  // LSB arrives first when set
    logic twos;       // invert word MSB when set
  } frame_cfg_t;

endpackage

// File: rtl/adc_deser_sampler.sv
// Matched synchronizer for bit clock, frame clock and lanes, followed by
// detection of both transitions of the bit clock.
module adc_deser_sampler #(
  parameter int LANES       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_i,
  input  logic             fclk_i,
  input  logic [LANES-1:0] lane_i,
  output logic             bit_stb_o,
  output logic             fbit_o,
  output logic [LANES-1:0] dbit_o
);
  localparam int VW = LANES + 2;

  logic [SYNC_STAGES-1:0][VW-1:0] sync_q;
  logic [VW-1:0]                  sync_last;
  logic                           bclk_prev;

  assign sync_last = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= {bclk_i, fclk_i, lane_i};
      for (int g = 1; g < SYNC_STAGES; g++) begin
        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  // All three outputs come from the same synchronizer stage, so the data
  // bits stay aligned with the detected bit-clock transition.
  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_prev <= 1'b0;
      bit_stb_o <= 1'b0;
      fbit_o    <= 1'b0;
      dbit_o    <= '0;
    end else begin
      bclk_prev <= sync_last[VW-1];
      bit_stb_o <= sync_last[VW-1] ^ bclk_prev;
      fbit_o    <= sync_last[VW-2];
      dbit_o    <= sync_last[LANES-1:0];
    end
  end
endmodule

// File: rtl/adc_deser_tracker.sv
// Bit-position counter, frame lock, configuration capture and
// misalignment detection, shared by all lanes.
module adc_deser_tracker
  import adc_deser_pkg::*;
#(
  parameter int WMAX   = 12,
  parameter int WSHORT = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_stb_i,
  input  logic       fbit_i,
  input  frame_cfg_t cfg_i,
  output logic       shift_en_o,
  output logic       last_o,
  output frame_cfg_t cfg_eff_o,
  output logic       align_lost_o
);
  localparam int CW = $clog2(WMAX);
  localparam logic [CW-1:0] LONG_M1  = CW'(WMAX - 1);
  localparam logic [CW-1:0] SHORT_M1 = CW'(WSHORT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] idx;
  logic [CW-1:0] len_m1;
  logic          fprev_q;
  logic          locked_q;
  logic          lost_q;
  frame_cfg_t    cfg_q;
  logic          rise;

  always_comb begin
    rise       = bit_stb_i & fbit_i & ~fprev_q;
    cfg_eff_o  = rise ? cfg_i : cfg_q;
    len_m1     = cfg_eff_o.short_w ? SHORT_M1 : LONG_M1;
    idx        = rise ? '0 : cnt_q;
    shift_en_o = bit_stb_i & (rise | locked_q);
    last_o     = shift_en_o & (idx == len_m1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      fprev_q  <= 1'b0;
      locked_q <= 1'b0;
      lost_q   <= 1'b0;
      cfg_q    <= '0;
    end else begin
      if (bit_stb_i) begin
        fprev_q <= fbit_i;
      end
      if (rise) begin
        locked_q <= 1'b1;
        cfg_q    <= cfg_i;
        if (locked_q && (cnt_q != '0)) begin
          lost_q <= 1'b1;
        end
      end
      if (shift_en_o) begin
        cnt_q <= last_o ? '0 : CW'(idx + 1'b1);
      end
    end
  end

  assign align_lost_o = lost_q;
endmodule

// File: rtl/adc_deser_lane.sv
// One lane: shift register in either bit order, justification and coding.
module adc_deser_lane
  import adc_deser_pkg::*;
#(
  parameter int WMAX   = 12,
  parameter int WSHORT = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en_i,
  input  logic            dbit_i,
  input  frame_cfg_t      cfg_i,
  output logic [WMAX-1:0] word_o
);
  localparam int PAD = WMAX - WSHORT;
  localparam logic [WMAX-1:0] LOWMASK = WMAX'((1 << PAD) - 1);
  localparam logic [WMAX-1:0] TOPBIT  = WMAX'(1) << (WMAX - 1);

  logic [WMAX-1:0] sh_q;
  logic [WMAX-1:0] sh_nxt;
  logic [WMAX-1:0] just;

  always_comb begin
    if (cfg_i.lsb_first) sh_nxt = {dbit_i, sh_q[WMAX-1:1]};
    else                 sh_nxt = {sh_q[WMAX-2:0], dbit_i};

    // A short LSB-first word already sits in the top bits; a short
    // MSB-first word sits in the bottom bits and is moved up.
    just = sh_nxt;
    if (cfg_i.short_w) begin
      if (cfg_i.lsb_first) just = sh_nxt & ~LOWMASK;
      else                 just = sh_nxt << PAD;
    end
    word_o = cfg_i.twos ? (just ^ TOPBIT) : just;
  end

  always_ff @(posedge clk) begin
    if (rst)             sh_q <= '0;
    else if (shift_en_i) sh_q <= sh_nxt;
  end
endmodule

// File: rtl/adc_frame_deser.sv
module adc_frame_deser
  import adc_deser_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int WMAX        = 12,
  parameter int WSHORT      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bclk_i,
  input  logic                  fclk_i,
  input  logic [LANES-1:0]      lane_i,
  input  logic                  cfg_short_i,
  input  logic                  cfg_lsb_first_i,
  input  logic                  cfg_twos_i,
  output logic [LANES*WMAX-1:0] samp_o,
  output logic                  samp_valid_o,
  output logic                  align_lost_o
);
  logic                  bit_stb;
  logic                  fbit;
  logic [LANES-1:0]      dbit;
  logic                  shift_en;
  logic                  frm_last;
  frame_cfg_t            cfg_in;
  frame_cfg_t            cfg_eff;
  logic [LANES*WMAX-1:0] words_flat;

  always_comb begin
    cfg_in.short_w   = cfg_short_i;
    cfg_in.lsb_first = cfg_lsb_first_i;
    cfg_in.twos      = cfg_twos_i;
  end

  adc_deser_sampler #(
    .LANES(LANES), .SYNC_STAGES(SYNC_STAGES)
  ) u_smp (
    .clk(clk), .rst(rst), .bclk_i(bclk_i), .fclk_i(fclk_i), .lane_i(lane_i),
    .bit_stb_o(bit_stb), .fbit_o(fbit), .dbit_o(dbit)
  );

  adc_deser_tracker #(
    .WMAX(WMAX), .WSHORT(WSHORT)
  ) u_trk (
    .clk(clk), .rst(rst), .bit_stb_i(bit_stb), .fbit_i(fbit), .cfg_i(cfg_in),
    .shift_en_o(shift_en), .last_o(frm_last), .cfg_eff_o(cfg_eff),
    .align_lost_o(align_lost_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    adc_deser_lane #(
      .WMAX(WMAX), .WSHORT(WSHORT)
    ) u_lane (
      .clk(clk), .rst(rst), .shift_en_i(shift_en), .dbit_i(dbit[l]),
      .cfg_i(cfg_eff), .word_o(words_flat[l*WMAX +: WMAX])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_o       <= '0;
      samp_valid_o <= 1'b0;
    end else begin
      samp_valid_o <= frm_last;
      if (frm_last) samp_o <= words_flat;
    end
  end
endmodule

// File: rtl/adc_deser_chk.sv
module adc_deser_chk #(
  parameter int LANES  = 8,
  parameter int WMAX   = 12,
  parameter int WSHORT = 10
) (
  input logic                  clk,
  input logic                  rst,
  input logic [LANES*WMAX-1:0] samp_o,
  input logic                  samp_valid_o,
  input logic                  align_lost_o,
  input logic                  last,
  input logic                  short_eff
);
  localparam int PAD = WMAX - WSHORT;

  logic pad_zero;
  always_comb begin
    pad_zero = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (samp_o[l*WMAX +: PAD] != '0) pad_zero = 1'b0;
    end
  end

  // R1: strobe lasts one cycle
  p_valid_single_r1: assert property (@(posedge clk) disable iff (rst)
    samp_valid_o |=> !samp_valid_o);

  // R1: strobe follows the word-complete decision
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    last |=> samp_valid_o);

  // R11: output holds between strobes
  p_out_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !samp_valid_o |-> $stable(samp_o));

  // R8: flag is sticky
  p_lost_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    align_lost_o |=> align_lost_o);

  // R3: pad bits are zero for short words
  p_short_pad_r3: assert property (@(posedge clk) disable iff (rst)
    (last && short_eff) |=> pad_zero);
endmodule

bind adc_frame_deser adc_deser_chk #(
  .LANES(LANES), .WMAX(WMAX), .WSHORT(WSHORT)
) u_chk (
  .clk(clk), .rst(rst), .samp_o(samp_o), .samp_valid_o(samp_valid_o),
  .align_lost_o(align_lost_o), .last(frm_last), .short_eff(cfg_eff.short_w)
);

// File: tb/test_adc_frame_deser.sv
module test_adc_frame_deser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b0;
  logic        fclk = 1'b0;
  logic [7:0]  lane = '0;
  logic        c_short = 1'b0, c_lsb = 1'b0, c_twos = 1'b0;
  logic [95:0] samp;
  logic        svalid, alost;

  int total = 0, bad = 0, nvalid = 0, unexp = 0;
  bit done = 0;

  logic [95:0] exp_mem [0:127];
  string       exp_tag [0:127];
  int          exp_wr = 0, exp_rd = 0;
  logic [95:0] last_exp = '0;

  // configuration applied in the middle of a frame (R9 scenario)
  logic        n_short, n_lsb, n_twos;

  always #2 clk = ~clk;

  adc_frame_deser i_adc_frame_deser (
    .clk(clk), .rst(rst), .bclk_i(bclk), .fclk_i(fclk), .lane_i(lane),
    .cfg_short_i(c_short), .cfg_lsb_first_i(c_lsb), .cfg_twos_i(c_twos),
    .samp_o(samp), .samp_valid_o(svalid), .align_lost_o(alost)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && svalid) begin
      nvalid++;
      if (exp_rd < exp_wr) begin
        for (int l = 0; l < 8; l++)
          chk(exp_tag[exp_rd], 32'(samp[l*12 +: 12]), 32'(exp_mem[exp_rd][l*12 +: 12]));
        exp_rd++;
      end else begin
        unexp++;
      end
    end
  end

  function automatic logic [11:0] gen(int k, int l, bit s);
    logic [11:0] v;
    case (k)
      0: v = 12'h000;
      1: v = 12'hfff;
      2: v = s ? 12'h200 : 12'h800;
      3: v = 12'h001;
      default: v = 12'((k * 1103) + (l * 2731) + (k * l * 97) + 5);
    endcase
    return s ? (v & 12'h3ff) : v;
  endfunction

  function automatic logic [11:0] fmt(logic [11:0] w, bit s, bit t);
    logic [11:0] j;
    j = s ? {w[9:0], 2'b00} : w;
    return t ? (j ^ 12'h800) : j;
  endfunction

  task automatic send_bit(input logic [7:0] d, input logic f);
    @(negedge clk);
    lane = d;
    fclk = f;
    repeat (2) @(negedge clk);
    bclk = ~bclk;   // R5: every transition carries a bit
    repeat (1) @(negedge clk);
  endtask

  // Sends nbits of a frame; at bit flip_at the configuration inputs change.
  task automatic send_frame(input logic [11:0] w [8], input bit s, input bit lsb,
                            input int nbits, input int flip_at);
    int n;
    n = s ? 10 : 12;
    for (int i = 0; i < nbits; i++) begin
      logic [7:0] d;
      int pos;
      if (i == flip_at) begin
        c_short = n_short; c_lsb = n_lsb; c_twos = n_twos;
      end
      pos = lsb ? i : (n - 1 - i);
      for (int l = 0; l < 8; l++) d[l] = w[l][pos];
      send_bit(d, (i < n / 2));
    end
  endtask

  task automatic push_exp(input logic [11:0] w [8], input bit s, input bit t, input string tag);
    logic [95:0] v;
    for (int l = 0; l < 8; l++) v[l*12 +: 12] = fmt(w[l], s, t);
    exp_mem[exp_wr] = v;
    exp_tag[exp_wr] = tag;
    exp_wr++;
    last_exp = v;
  endtask

  task automatic do_reset();
    bclk = 1'b0; fclk = 1'b0;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] w [8];
    string tag;
    int v0;

    do_reset();
    // R10: reset state
    chk("R10", 32'(samp == '0), 1);
    chk("R10", 32'(svalid), 0);
    chk("R10", 32'(alost), 0);

    // R6: bits before the first frame-clock rise are ignored
    for (int i = 0; i < 14; i++) send_bit(8'(i * 37 + 11), 1'b0);
    repeat (10) @(negedge clk);
    chk("R6", 32'(nvalid), 0);

    // Sweep all configurations and patterns (R2, R3, R4, R7)
    for (int c = 0; c < 8; c++) begin
      bit s, lb, t;
      s = c[0]; lb = c[1]; t = c[2];
      c_short = s; c_lsb = lb; c_twos = t;
      n_short = s; n_lsb = lb; n_twos = t;
      if (t)       tag = "R7";
      else if (lb) tag = "R4";
      else if (s)  tag = "R3";
      else         tag = "R2";
      for (int k = 0; k < 6; k++) begin
        for (int l = 0; l < 8; l++) w[l] = gen(k + c, l, s);
        push_exp(w, s, t, tag);
        send_frame(w, s, lb, s ? 10 : 12, -1);
      end
    end
    repeat (20) @(negedge clk);
    chk("R5", 32'(nvalid), 48);
    chk("R1", 32'(exp_rd), 32'(exp_wr));
    chk("R6", 32'(alost), 0);

    // R11: output holds while the link is idle
    repeat (50) @(negedge clk);
    chk("R11", 32'(samp == last_exp), 1);

    // R9: mid-frame configuration change applies to the next frame only
    c_short = 0; c_lsb = 0; c_twos = 0;
    n_short = 1; n_lsb = 1; n_twos = 1;
    for (int l = 0; l < 8; l++) w[l] = gen(9, l, 0);
    push_exp(w, 0, 0, "R9");
    send_frame(w, 0, 0, 12, 3);
    for (int l = 0; l < 8; l++) w[l] = gen(10, l, 1);
    push_exp(w, 1, 1, "R9");
    send_frame(w, 1, 1, 10, -1);
    repeat (20) @(negedge clk);
    chk("R9", 32'(exp_rd), 32'(exp_wr));

    // R8: misplaced frame-clock rise
    c_short = 0; c_lsb = 0; c_twos = 0;
    n_short = 0; n_lsb = 0; n_twos = 0;
    v0 = nvalid;
    for (int l = 0; l < 8; l++) w[l] = gen(11, l, 0);
    send_frame(w, 0, 0, 8, -1);          // truncated, must be dropped
    for (int l = 0; l < 8; l++) w[l] = gen(12, l, 0);
    push_exp(w, 0, 0, "R8");
    send_frame(w, 0, 0, 12, -1);
    repeat (20) @(negedge clk);
    chk("R8", 32'(alost), 1);
    chk("R8", 32'(nvalid - v0), 1);
    for (int l = 0; l < 8; l++) w[l] = gen(13, l, 0);
    push_exp(w, 0, 0, "R8");
    send_frame(w, 0, 0, 12, -1);
    repeat (20) @(negedge clk);
    chk("R8", 32'(alost), 1);
    chk("R8", 32'(exp_rd), 32'(exp_wr));
    chk("R6", 32'(unexp), 0);

    do_reset();
    chk("R10", 32'(alost), 0);
    chk("R10", 32'(samp == '0), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule